// File: doc/BRIEF.md
# Front panel console controller

This block is the command engine behind a keypad-driven programmer's console for a minicomputer. It takes single-cycle key events (eight octal digits plus a set of function keys) along with a level-sensitive Control modifier. From these it maintains an 18-bit entry buffer, an address register and a switch register, and it drives an 18-bit value for a six-digit octal display together with four status lamps.

To read or write memory, the console first asks the CPU to stop. It raises a halt request and waits for the CPU's grant. It then runs one transfer on a simple bus-master port, where the request is held until an acknowledge arrives from the slave. That acknowledge comes from another clock domain, so it passes through a synchronizer before use. A transfer that is never acknowledged is abandoned after a bounded wait and flagged as a bus error.

The run-affecting keys only act when Control is held. These are Initialize, Halt and Continue. The shared halt/step key halts the CPU with Control and single-steps it without Control. Step and Continue are only honoured while the CPU reports itself halted.

Top module: `panel_ctl`

## Requirements
- R1: A digit key (key code 0 to 7) shifts the 18-bit entry buffer left by three bits, places the digit in bits 2:0 and drops the top digit. The display then shows the new buffer value.
- R2: Clear (code 8) zeroes the entry buffer and the display and turns off the bus error lamp.
- R3: Load Address (code 9) copies the entry buffer into the address register and displays it. Display Address (code 10) shows the address register.
- R4: Load Switch Register (code 11) copies the entry buffer to the switch register output, displays it and lights the switch-display lamp. Any other accepted key turns that lamp off.
- R5: Initialize (code 16) produces a one-cycle initialize pulse only when Control is held. Without Control it has no effect.
- R6: The halt/step key (code 14) raises the halt request when Control is held. Without Control it produces a one-cycle step pulse if the CPU grants halt, and has no effect otherwise.
- R7: For Examine or Deposit the halt request is raised first. The bus request rises only after the halt grant is seen, and the halt request stays high afterwards.
- R8: The slave acknowledge passes through a two-flop synchronizer. Examine (code 12) shows the data returned with the acknowledge.
- R9: Deposit (code 13) writes the entry buffer to the address and displays it. An Examine that directly follows an Examine, or a Deposit that directly follows a Deposit, first advances the address by 2.
- R10: If no acknowledge is seen within 64 cycles of the bus request, the request is dropped. The bus error lamp then lights and stays lit until Clear.
- R11: Continue (code 15) with Control while the CPU grants halt drops the halt request. One cycle later a one-cycle continue pulse follows.
- R12: The run lamp shows the inverse of the halt grant, one cycle late. The maintenance lamp is lit while a console bus sequence is in progress.
- R13: Keys arriving while a bus sequence or a pending continue is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Console clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | One-cycle key event strobe |
| key_code | input | 5 | Key code: 0-7 digits, 8-16 function keys |
| ctrl_mod | input | 1 | Control modifier held |
| halt_grant | input | 1 | CPU acknowledges it is halted |
| halt_req | output | 1 | Request for the CPU to halt |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | 18 | Transfer address |
| bus_wdata | output | 18 | Write data |
| bus_rdata | input | 18 | Read data, valid with acknowledge |
| bus_ssyn | input | 1 | Asynchronous slave acknowledge |
| disp | output | 18 | Six octal digits for the display |
| swreg | output | 18 | Switch register value |
| ind_swdisp | output | 1 | Switch register shown on the display |
| ind_buserr | output | 1 | Transfer timed out |
| ind_maint | output | 1 | Console bus sequence active |
| ind_run | output | 1 | CPU running |
| cont_pulse | output | 1 | Continue command |
| step_pulse | output | 1 | Single instruction step command |
| init_pulse | output | 1 | Initialize command |

## Verification
The bench probes several corner cases:
- Digit entry past six digits: a buffer that does not drop the top digit would show a wrong value.
- Back-to-back Examines and Deposits: a design that forgets which operation came last would step the address when it should not, or fail to step it when it should.
- Control-gated keys pressed without Control, and Step or Continue pressed while the CPU runs: a loose gate would emit stray pulses.
- A slave that never answers, followed by a plain digit key: a bad timeout would hang the bus request, or the error lamp would clear too early.
- A digit pressed mid-transfer, then read back through Load Switch Register: leaky busy gating would corrupt the entry buffer.

// File: rtl/panel_pkg.sv
package panel_pkg;
  localparam int KEY_W = 5;

  typedef enum logic [KEY_W-1:0] {
    KEY_CLEAR    = 5'd8,
    KEY_LDADDR   = 5'd9,
    KEY_SHOWADDR = 5'd10,
    KEY_LDSWR    = 5'd11,
    KEY_EXAM     = 5'd12,
    KEY_DEP      = 5'd13,
    KEY_HALTSTEP = 5'd14,
    KEY_CONT     = 5'd15,
    KEY_INIT     = 5'd16
  } fkey_e;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_HWAIT, SEQ_XFER, SEQ_REL} seq_e;
  typedef enum logic [1:0] {OP_NONE, OP_EXAM, OP_DEP} op_e;
endpackage

// File: rtl/panel_sync.sv
module panel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/panel_entry.sv
module panel_entry #(
  parameter int DW      = 18,
  parameter int DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               shift,
  input  logic [DIGIT_W-1:0] digit,
  output logic [DW-1:0]      val,
  output logic [DW-1:0]      val_next
);
  assign val_next = {val[DW-DIGIT_W-1:0], digit};

  always_ff @(posedge clk) begin
    if (rst)        val <= '0;
    else if (clr)   val <= '0;
    else if (shift) val <= val_next;
  end

  // R1: new digit lands in the low bits, older digits move up
  a_r1_digit_low: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr) |=> val[DIGIT_W-1:0] == $past(digit));
  a_r1_digits_up: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr) |=> val[DW-1:DIGIT_W] == $past(val[DW-DIGIT_W-1:0]));
  // R2: clear empties the buffer
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> val == '0);
endmodule

// File: rtl/panel_bus_seq.sv
module panel_bus_seq
  import panel_pkg::*;
#(
  parameter int DW      = 18,
  parameter int TIMEOUT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [DW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic          halt_set,
  input  logic          halt_clr,
  input  logic          halt_grant,
  input  logic          ack,
  input  logic [DW-1:0] rdata_in,
  output logic          halt_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          tout,
  output logic          busy,
  output logic          active
);
  localparam int TMR_W = $clog2(TIMEOUT);

  seq_e             state;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      tmr       <= '0;
      halt_req  <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_done   <= 1'b0;
      rd_data   <= '0;
      tout      <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      tout    <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            halt_req  <= 1'b1;
            bus_we    <= start_we;
            bus_addr  <= start_addr;
            bus_wdata <= start_wdata;
            state     <= SEQ_HWAIT;
          end else if (halt_set) begin
            halt_req <= 1'b1;
          end else if (halt_clr) begin
            halt_req <= 1'b0;
          end
        end
        SEQ_HWAIT: begin
          if (halt_grant) begin
            bus_req <= 1'b1;
            tmr     <= '0;
            state   <= SEQ_XFER;
          end
        end
        SEQ_XFER: begin
          if (ack) begin
            bus_req <= 1'b0;
            if (!bus_we) begin
              rd_done <= 1'b1;
              rd_data <= rdata_in;
            end
            state <= SEQ_REL;
          end else if (tmr == TMR_W'(TIMEOUT - 1)) begin
            bus_req <= 1'b0;
            tout    <= 1'b1;
            state   <= SEQ_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SEQ_REL: begin
          if (!ack) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign active = (state != SEQ_IDLE);
  assign busy   = active || rd_done || tout;

  // R7: a transfer only starts once the CPU has granted the halt
  a_r7_req_after_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(halt_grant));
  // R7: the halt request covers the whole transfer
  a_r7_req_under_halt: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> halt_req);
  // R10: an abort ends a live request
  a_r10_abort_ends_req: assert property (@(posedge clk) disable iff (rst)
    tout |-> ($past(bus_req) && !bus_req));
endmodule

// File: rtl/panel_ctl.sv
module panel_ctl
  import panel_pkg::*;
#(
  parameter int DW          = 18,
  parameter int DIGIT_W     = 3,
  parameter int TIMEOUT     = 64,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_STEP   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_valid,
  input  logic [4:0]    key_code,
  input  logic          ctrl_mod,
  input  logic          halt_grant,
  output logic          halt_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ssyn,
  output logic [DW-1:0] disp,
  output logic [DW-1:0] swreg,
  output logic          ind_swdisp,
  output logic          ind_buserr,
  output logic          ind_maint,
  output logic          ind_run,
  output logic          cont_pulse,
  output logic          step_pulse,
  output logic          init_pulse
);
  logic          ack_s;
  logic [DW-1:0] ent_val, ent_next;
  logic [DW-1:0] addr;
  op_e           last_op;
  logic          pend_cont;
  logic          seq_busy, rd_done, tout;
  logic [DW-1:0] rd_data;
  logic          acc;
  logic          k_digit, k_clr, k_ldad, k_disad, k_ldsr, k_exam, k_dep;
  logic          k_halt, k_step, k_cont, k_init, any_key, adv;
  logic [DW-1:0] tgt_addr;

  panel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(bus_ssyn), .dout(ack_s));

  assign acc = key_valid && !seq_busy && !pend_cont;

  always_comb begin
    k_digit = 1'b0; k_clr = 1'b0; k_ldad = 1'b0; k_disad = 1'b0;
    k_ldsr  = 1'b0; k_exam = 1'b0; k_dep = 1'b0; k_halt = 1'b0;
    k_step  = 1'b0; k_cont = 1'b0; k_init = 1'b0;
    if (acc) begin
      if (key_code[4:3] == 2'b00) k_digit = 1'b1;
      else begin
        case (key_code)
          KEY_CLEAR:    k_clr   = 1'b1;
          KEY_LDADDR:   k_ldad  = 1'b1;
          KEY_SHOWADDR: k_disad = 1'b1;
          KEY_LDSWR:    k_ldsr  = 1'b1;
          KEY_EXAM:     k_exam  = 1'b1;
          KEY_DEP:      k_dep   = 1'b1;
          KEY_HALTSTEP: begin
            if (ctrl_mod)        k_halt = 1'b1;
            else if (halt_grant) k_step = 1'b1;
          end
          KEY_CONT:     k_cont = ctrl_mod && halt_grant;
          KEY_INIT:     k_init = ctrl_mod;
          default:      ;
        endcase
      end
    end
  end

  assign any_key = k_digit | k_clr | k_ldad | k_disad | k_ldsr | k_exam |
                   k_dep | k_halt | k_step | k_cont | k_init;
  assign adv = (k_exam && last_op == OP_EXAM) || (k_dep && last_op == OP_DEP);
  assign tgt_addr = adv ? addr + DW'(ADDR_STEP) : addr;

  panel_entry #(.DW(DW), .DIGIT_W(DIGIT_W)) u_entry (
    .clk(clk), .rst(rst), .clr(k_clr), .shift(k_digit),
    .digit(key_code[DIGIT_W-1:0]), .val(ent_val), .val_next(ent_next));

  panel_bus_seq #(.DW(DW), .TIMEOUT(TIMEOUT)) u_seq (
    .clk(clk), .rst(rst),
    .start(k_exam | k_dep), .start_we(k_dep),
    .start_addr(tgt_addr), .start_wdata(ent_val),
    .halt_set(k_halt), .halt_clr(k_cont),
    .halt_grant(halt_grant), .ack(ack_s), .rdata_in(bus_rdata),
    .halt_req(halt_req), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_done(rd_done), .rd_data(rd_data), .tout(tout),
    .busy(seq_busy), .active(ind_maint));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= '0;
      swreg      <= '0;
      disp       <= '0;
      last_op    <= OP_NONE;
      pend_cont  <= 1'b0;
      ind_swdisp <= 1'b0;
      ind_buserr <= 1'b0;
      ind_run    <= 1'b0;
      cont_pulse <= 1'b0;
      step_pulse <= 1'b0;
      init_pulse <= 1'b0;
    end else begin
      cont_pulse <= pend_cont;
      pend_cont  <= k_cont;
      step_pulse <= k_step;
      init_pulse <= k_init;
      ind_run    <= !halt_grant;
      if (rd_done) disp <= rd_data;
      if (tout) begin
        ind_buserr <= 1'b1;
        last_op    <= OP_NONE;
      end
      if (any_key) begin
        ind_swdisp <= k_ldsr;
        last_op    <= k_exam ? OP_EXAM : (k_dep ? OP_DEP : OP_NONE);
      end
      if (k_digit) disp <= ent_next;
      if (k_clr) begin
        disp       <= '0;
        ind_buserr <= 1'b0;
      end
      if (k_ldad) begin
        addr <= ent_val;
        disp <= ent_val;
      end
      if (k_disad) disp <= addr;
      if (k_ldsr) begin
        swreg <= ent_val;
        disp  <= ent_val;
      end
      if (k_exam) addr <= tgt_addr;
      if (k_dep) begin
        addr <= tgt_addr;
        disp <= ent_val;
      end
    end
  end

  // R11: continue is only signalled after the halt request is gone
  a_r11_release_first: assert property (@(posedge clk) disable iff (rst)
    cont_pulse |-> !halt_req);
  // R6: a step is only issued to a halted CPU
  a_r6_step_halted: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> $past(halt_grant));
  // R5: initialize needs the Control modifier
  a_r5_init_ctrl: assert property (@(posedge clk) disable iff (rst)
    init_pulse |-> $past(ctrl_mod));
  // R4: the switch-display lamp is lit only by Load Switch Register
  a_r4_swdisp_src: assert property (@(posedge clk) disable iff (rst)
    $rose(ind_swdisp) |-> $past(key_valid && key_code == KEY_LDSWR));
  // R13: single-cycle command pulses never overlap a pending continue
  a_r13_pulse_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cont_pulse, step_pulse, init_pulse}));
endmodule

// File: tb/panel_ctl_bench.sv
module panel_ctl_bench;
  localparam int DW = 18;
  localparam logic [DW-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_valid = 1'b0;
  logic [4:0] key_code = '0;
  logic ctrl_mod = 1'b0;
  logic halt_grant = 1'b0;
  logic halt_req, bus_req, bus_we;
  logic [DW-1:0] bus_addr, bus_wdata, disp, swreg;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_ssyn = 1'b0;
  logic ind_swdisp, ind_buserr, ind_maint, ind_run;
  logic cont_pulse, step_pulse, init_pulse;

  always #5 clk = ~clk;

  panel_ctl u_panel_ctl (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
    .ctrl_mod(ctrl_mod), .halt_grant(halt_grant), .halt_req(halt_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ssyn(bus_ssyn),
    .disp(disp), .swreg(swreg), .ind_swdisp(ind_swdisp),
    .ind_buserr(ind_buserr), .ind_maint(ind_maint), .ind_run(ind_run),
    .cont_pulse(cont_pulse), .step_pulse(step_pulse), .init_pulse(init_pulse));

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0o expected=%0o at %0t", req, act, exp, $time);
    end
  endtask

  // CPU: grants halt a few cycles after the request, drops it at once
  int gcnt = 0;
  always @(negedge clk) begin
    if (!halt_req) begin halt_grant <= 1'b0; gcnt <= 0; end
    else if (!halt_grant) begin
      if (gcnt == 2) halt_grant <= 1'b1; else gcnt <= gcnt + 1;
    end
  end

  // Memory slave with configurable delay or silence
  logic [DW-1:0] smem [int];
  int sdelay = 3;
  bit snoresp = 1'b0;
  int scnt = 0;
  always @(negedge clk) begin
    if (!bus_req) begin bus_ssyn <= 1'b0; scnt <= 0; end
    else if (!bus_ssyn && !snoresp) begin
      if (scnt == sdelay) begin
        bus_ssyn <= 1'b1;
        if (bus_we) smem[int'(bus_addr)] = bus_wdata;
        else bus_rdata <= smem.exists(int'(bus_addr)) ? smem[int'(bus_addr)]
                                                      : (bus_addr ^ 18'o525252);
      end else scnt <= scnt + 1;
    end
  end

  // Pulse counters
  int n_cont = 0, n_step = 0, n_init = 0;
  always @(negedge clk) if (cmp_en) begin
    if (cont_pulse) n_cont++;
    if (step_pulse) n_step++;
    if (init_pulse) n_init++;
  end

  // Behavioural reference model, advanced at each rising edge
  logic [DW-1:0] m_entry, m_addr, m_sw, m_disp, m_baddr, m_wdata, m_rdval;
  int m_last, m_st, m_tmr;
  bit m_swd, m_berr, m_hreq, m_breq, m_we, m_rdpend, m_tout, m_pcont;
  bit m_cont, m_step, m_init, m_s1, m_s2, m_run, m_busy;

  always @(posedge clk) begin
    if (rst) begin
      m_entry = '0; m_addr = '0; m_sw = '0; m_disp = '0; m_baddr = '0;
      m_wdata = '0; m_rdval = '0; m_last = 0; m_st = 0; m_tmr = 0;
      m_swd = 0; m_berr = 0; m_hreq = 0; m_breq = 0; m_we = 0; m_rdpend = 0;
      m_tout = 0; m_pcont = 0; m_cont = 0; m_step = 0; m_init = 0;
      m_s1 = 0; m_s2 = 0; m_run = 0;
    end else begin
      m_busy = (m_st != 0) || m_rdpend || m_tout || m_pcont;
      m_step = 0; m_init = 0;
      m_cont = m_pcont; m_pcont = 0;
      if (m_rdpend) begin m_disp = m_rdval; m_rdpend = 0; end
      if (m_tout) begin m_berr = 1; m_last = 0; m_tout = 0; end
      case (m_st)
        1: if (halt_grant) begin m_breq = 1; m_tmr = 0; m_st = 2; end
        2: if (m_s2) begin
             m_breq = 0;
             if (!m_we) begin m_rdpend = 1; m_rdval = bus_rdata; end
             m_st = 3;
           end else if (m_tmr == 63) begin m_breq = 0; m_tout = 1; m_st = 0; end
           else m_tmr++;
        3: if (!m_s2) m_st = 0;
        default: ;
      endcase
      if (key_valid && !m_busy) begin
        if (key_code < 8) begin
          m_entry = ((m_entry << 3) | DW'(key_code)) & MASK;
          m_disp = m_entry; m_last = 0; m_swd = 0;
        end else case (int'(key_code))
          8:  begin m_entry = 0; m_disp = 0; m_berr = 0; m_last = 0; m_swd = 0; end
          9:  begin m_addr = m_entry; m_disp = m_entry; m_last = 0; m_swd = 0; end
          10: begin m_disp = m_addr; m_last = 0; m_swd = 0; end
          11: begin m_sw = m_entry; m_disp = m_entry; m_swd = 1; m_last = 0; end
          12: begin
                if (m_last == 1) m_addr = (m_addr + 2) & MASK;
                m_baddr = m_addr; m_we = 0; m_hreq = 1; m_st = 1; m_last = 1; m_swd = 0;
              end
          13: begin
                if (m_last == 2) m_addr = (m_addr + 2) & MASK;
                m_baddr = m_addr; m_wdata = m_entry; m_disp = m_entry;
                m_we = 1; m_hreq = 1; m_st = 1; m_last = 2; m_swd = 0;
              end
          14: if (ctrl_mod) begin m_hreq = 1; m_last = 0; m_swd = 0; end
              else if (halt_grant) begin m_step = 1; m_last = 0; m_swd = 0; end
          15: if (ctrl_mod && halt_grant) begin
                m_hreq = 0; m_pcont = 1; m_last = 0; m_swd = 0;
              end
          16: if (ctrl_mod) begin m_init = 1; m_last = 0; m_swd = 0; end
          default: ;
        endcase
      end
      m_run = !halt_grant;
      m_s2 = m_s1; m_s1 = bus_ssyn;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) if (cmp_en) begin
    chk("R1 disp", 32'(disp), 32'(m_disp));
    chk("R4 ind_swdisp", 32'(ind_swdisp), 32'(m_swd));
    chk("R10 ind_buserr", 32'(ind_buserr), 32'(m_berr));
    chk("R12 ind_maint", 32'(ind_maint), 32'(m_st != 0));
    chk("R12 ind_run", 32'(ind_run), 32'(m_run));
    chk("R7 halt_req", 32'(halt_req), 32'(m_hreq));
    chk("R7 bus_req", 32'(bus_req), 32'(m_breq));
    chk("R11 cont_pulse", 32'(cont_pulse), 32'(m_cont));
    chk("R6 step_pulse", 32'(step_pulse), 32'(m_step));
    chk("R5 init_pulse", 32'(init_pulse), 32'(m_init));
    chk("R4 swreg", 32'(swreg), 32'(m_sw));
    if (bus_req) begin
      chk("R9 bus_addr", 32'(bus_addr), 32'(m_baddr));
      chk("R9 bus_we", 32'(bus_we), 32'(m_we));
      if (bus_we) chk("R9 bus_wdata", 32'(bus_wdata), 32'(m_wdata));
    end
  end

  task automatic press_nowait(input logic [4:0] code, input logic ctl);
    @(negedge clk);
    key_valid = 1'b1; key_code = code; ctrl_mod = ctl;
    @(negedge clk);
    key_valid = 1'b0; ctrl_mod = 1'b0;
  endtask

  task automatic wait_idle();
    while (ind_maint) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic press(input logic [4:0] code, input logic ctl);
    press_nowait(code, ctl);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset disp", 32'(disp), 0);
    chk("R7 reset halt_req", 32'(halt_req), 0);
    chk("R7 reset bus_req", 32'(bus_req), 0);

    // R1: seven digits, the first falls off the top
    for (int d = 1; d <= 7; d++) press(5'(d), 1'b0);
    chk("R1 seven digits", 32'(disp), 32'(18'o234567));

    // R2
    press(5'd8, 1'b0);
    chk("R2 clear", 32'(disp), 0);

    // R3
    press(5'd1, 1'b0); press(5'd0, 1'b0); press(5'd0, 1'b0);
    press(5'd9, 1'b0);
    chk("R3 load address", 32'(disp), 32'(18'o100));
    press(5'd7, 1'b0); press(5'd7, 1'b0);
    press(5'd10, 1'b0);
    chk("R3 display address", 32'(disp), 32'(18'o100));

    // R4
    press(5'd11, 1'b0);
    chk("R4 switch reg", 32'(swreg), 32'(18'o10077));
    chk("R4 lamp on", 32'(ind_swdisp), 1);
    press(5'd10, 1'b0);
    chk("R4 lamp off", 32'(ind_swdisp), 0);

    // R5 / R6: gated keys without Control while running
    press(5'd14, 1'b0);
    press(5'd15, 1'b0);
    press(5'd16, 1'b0);
    chk("R6 no halt without ctrl", 32'(halt_req), 0);
    chk("R6 no step while running", 32'(n_step), 0);
    chk("R11 no continue without ctrl", 32'(n_cont), 0);
    chk("R5 no init without ctrl", 32'(n_init), 0);

    // R7 / R8: examine at 100
    press(5'd12, 1'b0);
    chk("R7 halt held after examine", 32'(halt_req), 1);
    chk("R8 examine data", 32'(disp), 32'(18'o100 ^ 18'o525252));

    // R9: deposit, repeated deposit, repeated examine
    press(5'd8, 1'b0); press(5'd4, 1'b0); press(5'd2, 1'b0);
    press(5'd13, 1'b0);
    press(5'd13, 1'b0);
    press(5'd10, 1'b0);
    chk("R9 deposit advanced", 32'(disp), 32'(18'o102));
    press(5'd8, 1'b0); press(5'd1, 1'b0); press(5'd0, 1'b0); press(5'd0, 1'b0);
    press(5'd9, 1'b0);
    press(5'd12, 1'b0);
    chk("R9 deposited 100", 32'(disp), 32'(18'o42));
    press(5'd12, 1'b0);
    chk("R9 deposited 102", 32'(disp), 32'(18'o42));
    press(5'd12, 1'b0);
    chk("R9 advance to 104", 32'(disp), 32'(18'o104 ^ 18'o525252));

    // R6: step while halted
    press(5'd14, 1'b0);
    chk("R6 step pulse", 32'(n_step), 1);

    // R11 / R12: continue
    press(5'd15, 1'b1);
    chk("R11 continue pulse", 32'(n_cont), 1);
    chk("R11 halt released", 32'(halt_req), 0);
    chk("R12 run lamp", 32'(ind_run), 1);
    press(5'd14, 1'b0);
    chk("R6 step ignored while running", 32'(n_step), 1);

    // R5 / R6 with Control
    press(5'd16, 1'b1);
    chk("R5 init pulse", 32'(n_init), 1);
    press(5'd14, 1'b1);
    chk("R6 halt raised", 32'(halt_req), 1);
    chk("R12 run lamp off", 32'(ind_run), 0);

    // R10: silent slave
    snoresp = 1'b1;
    press(5'd12, 1'b0);
    chk("R10 bus error", 32'(ind_buserr), 1);
    chk("R10 request dropped", 32'(bus_req), 0);
    press(5'd3, 1'b0);
    chk("R10 error sticky", 32'(ind_buserr), 1);
    press(5'd8, 1'b0);
    chk("R10 cleared by clear", 32'(ind_buserr), 0);
    snoresp = 1'b0;

    // R13: digit during a slow transfer is dropped
    sdelay = 20;
    press(5'd5, 1'b0);
    press_nowait(5'd12, 1'b0);
    repeat (5) @(negedge clk);
    press_nowait(5'd3, 1'b0);
    wait_idle();
    press(5'd11, 1'b0);
    chk("R13 busy key ignored", 32'(disp), 32'(18'o5));

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule